// File: doc/BRIEF.md
# Register Bank Self-Test Master

This block is a hardware checker for a small bank of memory-mapped 32-bit registers reached over AXI4-Lite. A one-cycle start pulse launches a test. The block first writes a distinct word to every register, in ascending address order. Only after every write response has come back does it read the registers back, again in ascending order. Each returned word is compared with the word that was written.

The test stops at the first register that reads back wrong or returns an error response. At that point it reports done with pass low, along with the byte address of the offending register. Because each register gets its own pattern, the test catches aliased decoding. It also catches a register whose read mux is fed from some other source than the flop that the write updates.

The block is used as the master on a link to the register slave, typically during bring-up or a power-on check.

Top module: `regbank_selftest`

## Requirements
- R1: After reset, busy_o, done_o, pass_o, awvalid_o, wvalid_o, bready_o, arvalid_o and rready_o are all low, and fail_addr_o is zero.
- R2: Write n (n = 0..7) targets byte address BASE_ADDR + 4*n and carries data PAT_KEY ^ n. Writes are issued in ascending n. wstrb_o is all ones, and awprot_o and arprot_o are zero.
- R3: No read address is presented until all 8 write responses have been accepted.
- R4: awvalid_o and wvalid_o rise together for each write. Each stays high, with its payload stable, until its own ready is seen. The next write starts only after a B handshake.
- R5: Read n targets BASE_ADDR + 4*n in ascending n. arvalid_o stays high with a stable address until arready_i is seen. Read data is taken on the cycle where rvalid_i and rready_o are both high.
- R6: When all 8 read-back words equal their written patterns and every response is OKAY (2'b00), done_o goes high with pass_o high and fail_addr_o = 0.
- R7: A read-back word differing from PAT_KEY ^ n ends the test at register n: done_o high, pass_o low, fail_addr_o = BASE_ADDR + 4*n, and no further reads are issued.
- R8: A write response other than OKAY (2'b00) at register n ends the test at once with pass_o low and fail_addr_o = BASE_ADDR + 4*n. No reads are issued.
- R9: A read response other than OKAY at register n fails the test at register n, with the same reporting as R7.
- R10: busy_o goes high on the cycle after start_i is sampled while not busy. A start_i pulse while busy is ignored.
- R11: done_o, pass_o and fail_addr_o hold their values until the next accepted start_i. A start_i pulse while done is high begins a new test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Test launch pulse |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Test finished, result valid |
| pass_o | output | 1 | All registers matched |
| fail_addr_o | output | ADDR_W | Byte address of first failing register |
| awaddr_o | output | ADDR_W | Write address |
| awprot_o | output | 3 | Write protection, tied to zero |
| awvalid_o | output | 1 | Write address valid |
| awready_i | input | 1 | Write address ready |
| wdata_o | output | DATA_W | Write data |
| wstrb_o | output | DATA_W/8 | Write strobes |
| wvalid_o | output | 1 | Write data valid |
| wready_i | input | 1 | Write data ready |
| bresp_i | input | 2 | Write response |
| bvalid_i | input | 1 | Write response valid |
| bready_o | output | 1 | Write response ready |
| araddr_o | output | ADDR_W | Read address |
| arprot_o | output | 3 | Read protection, tied to zero |
| arvalid_o | output | 1 | Read address valid |
| arready_i | input | 1 | Read address ready |
| rdata_i | input | DATA_W | Read data |
| rresp_i | input | 2 | Read response |
| rvalid_i | input | 1 | Read data valid |
| rready_o | output | 1 | Read data ready |

## Verification
Every result is tied to a handshake edge. busy_o rises one cycle after an accepted start. Each new AW/W or AR request appears two cycles after the previous B or R handshake. done_o, pass_o and fail_addr_o settle directly after the clock edge that carries the final B or R handshake.

The bench drives all stimulus and samples all outputs on falling edges, so every check reads values that have settled since the last rising edge. Channel contents are checked in the slave model at the rising edge where each handshake occurs.

The result checks wait for done_o, bounded by a per-run timeout. They then compare the flags and the counts of completed writes and reads against values derived from the fault type and position. The run is swept over every register position, four fault kinds and two ready-stall patterns.

// File: rtl/regbank_selftest_pkg.sv
package regbank_selftest_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WR_GO, ST_WR_WAIT, ST_RD_GO, ST_RD_WAIT, ST_DONE
  } st_e;
  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/st_index.sv
module st_index #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         step_i,
  output logic [W-1:0] idx_o,
  output logic         last_o
);
  logic [W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (clear_i) idx_q <= '0;
    else if (step_i)  idx_q <= idx_q + 1'b1;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == W'(N - 1));
endmodule

// File: rtl/st_wr_chan.sv
module st_wr_chan
  import regbank_selftest_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] awaddr_o,
  output logic              awvalid_o,
  input  logic              awready_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wvalid_o,
  input  logic              wready_i,
  input  logic [1:0]        bresp_i,
  input  logic              bvalid_i,
  output logic              bready_o,
  output logic              fin_o,
  output logic              err_o
);
  logic              aw_q, w_q, act_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_q   <= 1'b0;
      w_q    <= 1'b0;
      act_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (go_i) begin
      aw_q   <= 1'b1;
      w_q    <= 1'b1;
      act_q  <= 1'b1;
      addr_q <= addr_i;
      data_q <= data_i;
    end else begin
      if (aw_q && awready_i) aw_q <= 1'b0;
      if (w_q && wready_i)   w_q  <= 1'b0;
      if (fin_o)             act_q <= 1'b0;
    end
  end

  assign awaddr_o  = addr_q;
  assign awvalid_o = aw_q;
  assign wdata_o   = data_q;
  assign wvalid_o  = w_q;
  // response accepted only once both request channels have handed off
  assign bready_o  = act_q && !aw_q && !w_q;
  assign fin_o     = bvalid_i && bready_o;
  assign err_o     = (bresp_i != RESP_OKAY);
endmodule

// File: rtl/st_rd_chan.sv
module st_rd_chan
  import regbank_selftest_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] expect_i,
  output logic [ADDR_W-1:0] araddr_o,
  output logic              arvalid_o,
  input  logic              arready_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [1:0]        rresp_i,
  input  logic              rvalid_i,
  output logic              rready_o,
  output logic              fin_o,
  output logic              bad_o
);
  logic              ar_q, r_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_q   <= 1'b0;
      r_q    <= 1'b0;
      addr_q <= '0;
      exp_q  <= '0;
    end else if (go_i) begin
      ar_q   <= 1'b1;
      addr_q <= addr_i;
      exp_q  <= expect_i;
    end else begin
      if (ar_q && arready_i) begin
        ar_q <= 1'b0;
        r_q  <= 1'b1;
      end
      if (fin_o) r_q <= 1'b0;
    end
  end

  assign araddr_o  = addr_q;
  assign arvalid_o = ar_q;
  assign rready_o  = r_q;
  assign fin_o     = rvalid_i && r_q;
  assign bad_o     = (rdata_i != exp_q) || (rresp_i != RESP_OKAY);
endmodule

// File: rtl/regbank_selftest.sv
module regbank_selftest
  import regbank_selftest_pkg::*;
#(
  parameter int                 NUM_REGS  = 8,
  parameter int                 ADDR_W    = 32,
  parameter int                 DATA_W    = 32,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 32'h4000_0000,
  parameter logic [DATA_W-1:0]  PAT_KEY   = 32'hA5C3_0F00
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                pass_o,
  output logic [ADDR_W-1:0]   fail_addr_o,
  output logic [ADDR_W-1:0]   awaddr_o,
  output logic [2:0]          awprot_o,
  output logic                awvalid_o,
  input  logic                awready_i,
  output logic [DATA_W-1:0]   wdata_o,
  output logic [DATA_W/8-1:0] wstrb_o,
  output logic                wvalid_o,
  input  logic                wready_i,
  input  logic [1:0]          bresp_i,
  input  logic                bvalid_i,
  output logic                bready_o,
  output logic [ADDR_W-1:0]   araddr_o,
  output logic [2:0]          arprot_o,
  output logic                arvalid_o,
  input  logic                arready_i,
  input  logic [DATA_W-1:0]   rdata_i,
  input  logic [1:0]          rresp_i,
  input  logic                rvalid_i,
  output logic                rready_o
);
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int OFF_LSB = $clog2(DATA_W / 8);

  st_e               st_q;
  logic              pass_q;
  logic [ADDR_W-1:0] fail_q;
  logic [IDX_W-1:0]  idx;
  logic              last;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_pat;
  logic              wr_fin, wr_err, rd_fin, rd_bad;
  logic              launch, idx_clr, idx_step;

  assign cur_addr = BASE_ADDR + (ADDR_W'(idx) << OFF_LSB);
  assign cur_pat  = PAT_KEY ^ DATA_W'(idx);

  assign launch   = start_i && (st_q == ST_IDLE || st_q == ST_DONE);
  assign idx_clr  = launch || (st_q == ST_WR_WAIT && wr_fin && !wr_err && last);
  assign idx_step = (st_q == ST_WR_WAIT && wr_fin && !wr_err && !last) ||
                    (st_q == ST_RD_WAIT && rd_fin && !rd_bad && !last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pass_q <= 1'b0;
      fail_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          st_q   <= ST_WR_GO;
          pass_q <= 1'b0;
          fail_q <= '0;
        end
        ST_WR_GO: st_q <= ST_WR_WAIT;
        ST_WR_WAIT: if (wr_fin) begin
          if (wr_err) begin
            st_q   <= ST_DONE;
            fail_q <= cur_addr;
          end else begin
            st_q <= last ? ST_RD_GO : ST_WR_GO;
          end
        end
        ST_RD_GO: st_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (rd_fin) begin
          if (rd_bad) begin
            st_q   <= ST_DONE;
            fail_q <= cur_addr;
          end else if (last) begin
            st_q   <= ST_DONE;
            pass_q <= 1'b1;
          end else begin
            st_q <= ST_RD_GO;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  st_index #(.N(NUM_REGS), .W(IDX_W)) u_idx (
    .clk_i, .rst_ni, .clear_i(idx_clr), .step_i(idx_step),
    .idx_o(idx), .last_o(last)
  );

  st_wr_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk_i, .rst_ni, .go_i(st_q == ST_WR_GO), .addr_i(cur_addr), .data_i(cur_pat),
    .awaddr_o, .awvalid_o, .awready_i, .wdata_o, .wvalid_o, .wready_i,
    .bresp_i, .bvalid_i, .bready_o, .fin_o(wr_fin), .err_o(wr_err)
  );

  st_rd_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i, .rst_ni, .go_i(st_q == ST_RD_GO), .addr_i(cur_addr), .expect_i(cur_pat),
    .araddr_o, .arvalid_o, .arready_i, .rdata_i, .rresp_i, .rvalid_i, .rready_o,
    .fin_o(rd_fin), .bad_o(rd_bad)
  );

  assign awprot_o    = 3'b000;
  assign arprot_o    = 3'b000;
  assign wstrb_o     = '1;
  assign busy_o      = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done_o      = (st_q == ST_DONE);
  assign pass_o      = pass_q;
  assign fail_addr_o = fail_q;
endmodule

// File: rtl/regbank_selftest_chk.sv
module regbank_selftest_chk #(
  parameter int                ADDR_W    = 32,
  parameter int                NUM_REGS  = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o,
  input logic [ADDR_W-1:0] fail_addr_o,
  input logic [ADDR_W-1:0] awaddr_o,
  input logic              awvalid_o,
  input logic              awready_i,
  input logic              wvalid_o,
  input logic              wready_i,
  input logic [ADDR_W-1:0] araddr_o,
  input logic              arvalid_o,
  input logic              arready_i
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = BASE_ADDR + ADDR_W'(4 * NUM_REGS);

  AST_AW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awvalid_o && !awready_i |=> awvalid_o && $stable(awaddr_o)); // R4
  AST_W_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid_o && !wready_i |=> wvalid_o); // R4
  AST_AW_W_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(awvalid_o) |-> $rose(wvalid_o)); // R4
  AST_AR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arvalid_o && !arready_i |=> arvalid_o && $stable(araddr_o)); // R5
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arvalid_o |-> !awvalid_o && !wvalid_o); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !awvalid_o && !wvalid_o && !arvalid_o); // R1
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o); // R10
  AST_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R11
  AST_FAIL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !pass_o |-> fail_addr_o >= BASE_ADDR && fail_addr_o < TOP_ADDR); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(pass_o) && $stable(fail_addr_o)); // R11
endmodule

bind regbank_selftest regbank_selftest_chk #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .pass_o(pass_o), .fail_addr_o(fail_addr_o),
  .awaddr_o(awaddr_o), .awvalid_o(awvalid_o), .awready_i(awready_i),
  .wvalid_o(wvalid_o), .wready_i(wready_i),
  .araddr_o(araddr_o), .arvalid_o(arvalid_o), .arready_i(arready_i)
);

// File: tb/sim_regbank_selftest.sv
`timescale 1ns/1ps
module sim_regbank_selftest;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [31:0] KEY  = 32'hA5C3_0F00;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic busy_o, done_o, pass_o;
  logic [31:0] fail_addr_o, awaddr_o, wdata_o, araddr_o, rdata_i;
  logic [2:0]  awprot_o, arprot_o;
  logic [3:0]  wstrb_o;
  logic awvalid_o, awready_i, wvalid_o, wready_i, bvalid_i, bready_o;
  logic arvalid_o, arready_i, rvalid_i, rready_o;
  logic [1:0] bresp_i, rresp_i;

  always #10 clk_i = ~clk_i; // 50 MHz

  regbank_selftest #(.BASE_ADDR(BASE), .PAT_KEY(KEY)) u0 (.*);

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0;
  int fault_mode = 0, fault_k = 0;
  logic slow = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // slave model
  logic [31:0] mem [8];
  logic [7:0]  lfsr;
  logic        aw_got, w_got;
  logic [2:0]  aw_idx, ar_idx;
  logic [31:0] w_dat;

  assign awready_i = slow ? lfsr[0] : 1'b1;
  assign wready_i  = slow ? lfsr[3] : 1'b1;
  assign arready_i = (slow ? lfsr[5] : 1'b1) && !rvalid_i;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr <= 8'h5B; aw_got <= 0; w_got <= 0; bvalid_i <= 0; rvalid_i <= 0;
      bresp_i <= 0; rresp_i <= 0; rdata_i <= 0; aw_idx <= 0; w_dat <= 0;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (awvalid_o && awready_i) begin
        chk(awaddr_o == BASE + 32'(4 * wr_cnt), "R2 awaddr", awaddr_o, BASE + 32'(4 * wr_cnt));
        chk(awprot_o == 3'b0, "R2 awprot", 32'(awprot_o), 0);
        aw_got <= 1; aw_idx <= awaddr_o[4:2];
      end
      if (wvalid_o && wready_i) begin
        chk(wdata_o == (KEY ^ 32'(wr_cnt)), "R2 wdata", wdata_o, KEY ^ 32'(wr_cnt));
        chk(wstrb_o == 4'hF, "R2 wstrb", 32'(wstrb_o), 32'hF);
        w_got <= 1; w_dat <= wdata_o;
      end
      if (aw_got && w_got && !bvalid_i && (!slow || lfsr[2])) begin
        mem[aw_idx] <= w_dat;
        bvalid_i <= 1;
        bresp_i  <= (fault_mode == 3 && int'(aw_idx) == fault_k) ? 2'b10 : 2'b00;
        aw_got <= 0; w_got <= 0;
      end
      if (bvalid_i && bready_o) begin
        bvalid_i <= 0;
        wr_cnt++;
      end
      if (arvalid_o && arready_i) begin
        chk(wr_cnt == 8, "R3 writes before read", 32'(wr_cnt), 8);
        chk(araddr_o == BASE + 32'(4 * rd_cnt), "R5 araddr", araddr_o, BASE + 32'(4 * rd_cnt));
        chk(arprot_o == 3'b0, "R2 arprot", 32'(arprot_o), 0);
        ar_idx = araddr_o[4:2];
        rvalid_i <= 1;
        rresp_i  <= (fault_mode == 4 && int'(ar_idx) == fault_k) ? 2'b10 : 2'b00;
        if (fault_mode == 1 && int'(ar_idx) == fault_k)      rdata_i <= mem[ar_idx] ^ 32'h1;
        else if (fault_mode == 2 && int'(ar_idx) == fault_k) rdata_i <= mem[ar_idx + 3'd1];
        else                                                  rdata_i <= mem[ar_idx];
      end
      if (rvalid_i && rready_o) begin
        rvalid_i <= 0;
        rd_cnt++;
      end
    end
  end

  task automatic run(input int mode, input int k, input bit slw, input bit mid_start);
    int n;
    bit ok_pass;
    fault_mode = mode; fault_k = k; slow = slw;
    wr_cnt = 0; rd_cnt = 0;
    for (int i = 0; i < 8; i++) mem[i] = 32'hDEAD_0000;
    @(negedge clk_i) start_i = 1;
    @(negedge clk_i) start_i = 0;
    chk(busy_o && !done_o, "R10 busy after start", {busy_o, done_o}, 2'b10);
    if (mid_start) begin
      repeat (6) @(negedge clk_i);
      start_i = 1;
      @(negedge clk_i) start_i = 0;
    end
    n = 0;
    while (!done_o && n < 4000) begin @(negedge clk_i); n++; end
    chk(done_o, "R6 done timeout", 32'(done_o), 1);
    ok_pass = (mode == 0);
    chk(pass_o == ok_pass, mode == 0 ? "R6 pass" : (mode == 3 ? "R8 pass" : (mode == 4 ? "R9 pass" : "R7 pass")),
        32'(pass_o), 32'(ok_pass));
    chk(fail_addr_o == (ok_pass ? 32'h0 : BASE + 32'(4 * k)),
        mode == 0 ? "R6 fail_addr" : (mode == 3 ? "R8 fail_addr" : (mode == 4 ? "R9 fail_addr" : "R7 fail_addr")),
        fail_addr_o, ok_pass ? 32'h0 : BASE + 32'(4 * k));
    chk(wr_cnt == (mode == 3 ? k + 1 : 8), "R8 write count", 32'(wr_cnt), 32'(mode == 3 ? k + 1 : 8));
    chk(rd_cnt == (mode == 3 ? 0 : (mode == 0 ? 8 : k + 1)), "R7 read count", 32'(rd_cnt),
        32'(mode == 3 ? 0 : (mode == 0 ? 8 : k + 1)));
    repeat (5) @(negedge clk_i);
    chk(done_o && !busy_o && pass_o == ok_pass, "R11 result held", {busy_o, done_o, pass_o},
        {1'b0, 1'b1, ok_pass});
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk({busy_o, done_o, pass_o, awvalid_o, wvalid_o, bready_o, arvalid_o, rready_o} == 8'h0,
        "R1 reset outputs", {busy_o, done_o, pass_o, awvalid_o, wvalid_o, bready_o, arvalid_o, rready_o}, 0);
    chk(fail_addr_o == 0, "R1 fail_addr reset", fail_addr_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R1 idle after reset", {busy_o, done_o}, 0);
    run(0, 0, 0, 0); // R6 clean, fast
    run(0, 0, 1, 0); // R6 clean, stalled
    run(0, 0, 1, 1); // R10 start ignored while busy
    for (int s = 0; s < 2; s++)
      for (int m = 1; m <= 4; m++)
        for (int k = 0; k < 8; k++)
          run(m, k, s[0], 0); // R7 R8 R9 per register
    run(0, 0, 0, 0); // R11 restart from done
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule